// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block chooses the address of the next instruction for a 32-bit single-cycle processor. It takes the current program counter, the instruction word and the two register operands already read for that instruction. From these it returns the next program counter, plus a request to write a return address into register 31. The flow kinds it resolves are:

- fall-through to the next word
- jumps within the current 256 MB region
- jumps through a register
- branches on equality or inequality of two registers
- four branches that test the sign of one register against zero
- a region jump that also records a return address

The address logic is purely combinational. A parameter selects whether the unit also holds the program counter in a register. That register clears to address 0 on a synchronous reset and loads the computed next address on every other clock. Fetch, register storage, exceptions and delay-slot sequencing sit outside the block. The delay slot shows up only in the return address, which skips one extra word.

Top module: `npc_unit`

## Requirements
- R1: With an opcode (instruction bits 31:26) outside 0x0..0x7, `next_pc_o` equals `pc_i + 4` and `link_we_o` is 0.
- R2: Opcode 0x2 sets `next_pc_o` to bits 31:28 of `pc_i + 4`, followed by instruction bits 25:0, followed by two zero bits.
- R3: Opcode 0x3 produces the same next address as R2, drives `link_we_o` to 1 and `link_val_o` to `pc_i + 8`.
- R4: Opcode 0x0 with function field (bits 5:0) equal to 0x08 sets `next_pc_o` to `rs_val_i`. Opcode 0x0 with any other function value gives `pc_i + 4`.
- R5: Opcode 0x4, when `rs_val_i == rd_val_i`, gives `pc_i + 4 + (sign-extended bits 15:0 shifted left by 2)`. Otherwise it gives `pc_i + 4`.
- R6: Opcode 0x5 takes the same target as R5 when `rs_val_i != rd_val_i`. Otherwise it gives `pc_i + 4`.
- R7: Opcode 0x1 reads a sub-op from bits 20:16. Sub-op 0 branches when `rs_val_i` is negative. Sub-op 1 branches when `rs_val_i` is zero or positive. Any other sub-op gives `pc_i + 4`. The branch target is as in R5.
- R8: Opcode 0x6 branches when signed `rs_val_i <= 0`, and opcode 0x7 branches when `rs_val_i > 0`. Each needs sub-op 0 in bits 20:16; a nonzero sub-op gives `pc_i + 4`.
- R9: `link_we_o` is 1 only for opcode 0x3.
- R10: `pc_q_o` becomes 0 on a clock edge with `rst` high. On any other edge it loads the `next_pc_o` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register |
| rst | input | 1 | Synchronous active-high reset of the PC register |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the register named by bits 25:21 |
| rd_val_i | input | 32 | Value of the register named by bits 20:16 |
| next_pc_o | output | 32 | Computed next instruction address |
| link_we_o | output | 1 | Write request for the return-address register |
| link_val_o | output | 32 | Return address, current PC plus 8 |
| pc_q_o | output | 32 | Registered program counter |

## Verification
`next_pc_o`, `link_we_o` and `link_val_o` are combinational. They are due in the same cycle the operands are applied. `pc_q_o` is due one clock edge later. The bench drives each vector just after a falling edge and checks the combinational outputs one nanosecond later. It then waits for the rising edge and checks `pc_q_o` one nanosecond after it, against the next address it predicted for that vector.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

    localparam int XLEN   = 32;
    localparam int OPW    = 6;
    localparam int SUBW   = 5;
    localparam int FUNCW  = 6;
    localparam int IMMW   = 16;
    localparam int TGTW   = 26;
    localparam int REGION = XLEN - TGTW - 2;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [OPW-1:0]  op_t;

    localparam op_t OP_SPECIAL = 6'h00;
    localparam op_t OP_ZCMP    = 6'h01;
    localparam op_t OP_JREGION = 6'h02;
    localparam op_t OP_JLINK   = 6'h03;
    localparam op_t OP_BREQ    = 6'h04;
    localparam op_t OP_BRNE    = 6'h05;
    localparam op_t OP_BRLEZ   = 6'h06;
    localparam op_t OP_BRGTZ   = 6'h07;

    localparam logic [FUNCW-1:0] FN_JREG  = 6'h08;
    localparam logic [SUBW-1:0]  SUB_LTZ  = 5'd0;
    localparam logic [SUBW-1:0]  SUB_GEZ  = 5'd1;

    localparam word_t STEP_WORD = word_t'(4);
    localparam word_t STEP_LINK = word_t'(8);

    typedef enum logic [3:0] {
        FL_SEQ, FL_JUMP, FL_JLINK, FL_JREG,
        FL_BEQ, FL_BNE, FL_BLTZ, FL_BGEZ, FL_BLEZ, FL_BGTZ
    } flow_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic eq;
    } cmp_t;

    typedef struct packed {
        word_t next_pc;
        logic  link_we;
        word_t link_val;
    } npc_res_t;

    function automatic word_t branch_disp(input logic [IMMW-1:0] off);
        return {{(XLEN-IMMW-2){off[IMMW-1]}}, off, 2'b00};
    endfunction

    function automatic word_t region_target(input word_t seq_pc,
                                            input logic [TGTW-1:0] tgt);
        return {seq_pc[XLEN-1 -: REGION], tgt, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
    import npc_pkg::*;
(
    input  op_t                 op_i,
    input  logic [SUBW-1:0]     sub_i,
    input  logic [FUNCW-1:0]    funct_i,
    output flow_e               kind_o
);
    always_comb begin
        kind_o = FL_SEQ;
        unique case (op_i)
            OP_SPECIAL: kind_o = (funct_i == FN_JREG) ? FL_JREG : FL_SEQ;
            OP_ZCMP: begin
                if (sub_i == SUB_LTZ)      kind_o = FL_BLTZ;
                else if (sub_i == SUB_GEZ) kind_o = FL_BGEZ;
                else                       kind_o = FL_SEQ;
            end
            OP_JREGION: kind_o = FL_JUMP;
            OP_JLINK:   kind_o = FL_JLINK;
            OP_BREQ:    kind_o = FL_BEQ;
            OP_BRNE:    kind_o = FL_BNE;
            OP_BRLEZ:   kind_o = (sub_i == '0) ? FL_BLEZ : FL_SEQ;
            OP_BRGTZ:   kind_o = (sub_i == '0) ? FL_BGTZ : FL_SEQ;
            default:    kind_o = FL_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_cond.sv
`timescale 1ns/1ps
module npc_cond
    import npc_pkg::*;
(
    input  flow_e   kind_i,
    input  word_t   rs_val_i,
    input  word_t   rd_val_i,
    output logic    taken_o
);
    cmp_t c;

    // sign bit and zero detect only; no subtractor
    always_comb begin
        c.neg  = rs_val_i[XLEN-1];
        c.zero = ~|rs_val_i;
        c.eq   = (rs_val_i == rd_val_i);
    end

    always_comb begin
        unique case (kind_i)
            FL_BEQ:  taken_o = c.eq;
            FL_BNE:  taken_o = ~c.eq;
            FL_BLTZ: taken_o = c.neg;
            FL_BGEZ: taken_o = ~c.neg;
            FL_BLEZ: taken_o = c.neg | c.zero;
            FL_BGTZ: taken_o = ~c.neg & ~c.zero;
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target
    import npc_pkg::*;
(
    input  word_t            pc_i,
    input  word_t            rs_val_i,
    input  logic [TGTW-1:0]  tgt_i,
    input  flow_e            kind_i,
    input  logic             taken_i,
    output npc_res_t         res_o
);
    word_t seq_pc;
    word_t br_pc;
    word_t jmp_pc;

    always_comb begin
        seq_pc = pc_i + STEP_WORD;
        br_pc  = seq_pc + branch_disp(tgt_i[IMMW-1:0]);
        jmp_pc = region_target(seq_pc, tgt_i);
    end

    always_comb begin
        res_o.link_we  = 1'b0;
        res_o.link_val = pc_i + STEP_LINK;
        unique case (kind_i)
            FL_JUMP:  res_o.next_pc = jmp_pc;
            FL_JLINK: begin
                res_o.next_pc = jmp_pc;
                res_o.link_we = 1'b1;
            end
            FL_JREG:  res_o.next_pc = rs_val_i;
            FL_BEQ, FL_BNE, FL_BLTZ, FL_BGEZ, FL_BLEZ, FL_BGTZ:
                      res_o.next_pc = taken_i ? br_pc : seq_pc;
            default:  res_o.next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
    import npc_pkg::*;
#(
    parameter bit REG_PC = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rd_val_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              link_we_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic [XLEN-1:0]   pc_q_o
);
    flow_e    kind;
    logic     taken;
    npc_res_t res;

    npc_decode u_dec (
        .op_i    (instr_i[XLEN-1 -: OPW]),
        .sub_i   (instr_i[IMMW +: SUBW]),
        .funct_i (instr_i[FUNCW-1:0]),
        .kind_o  (kind)
    );

    npc_cond u_cond (
        .kind_i   (kind),
        .rs_val_i (rs_val_i),
        .rd_val_i (rd_val_i),
        .taken_o  (taken)
    );

    npc_target u_tgt (
        .pc_i     (pc_i),
        .rs_val_i (rs_val_i),
        .tgt_i    (instr_i[TGTW-1:0]),
        .kind_i   (kind),
        .taken_i  (taken),
        .res_o    (res)
    );

    assign next_pc_o  = res.next_pc;
    assign link_we_o  = res.link_we;
    assign link_val_o = res.link_val;

    generate
        if (REG_PC) begin : g_pc_reg
            word_t pc_q;
            always_ff @(posedge clk) begin
                if (rst) pc_q <= '0;
                else     pc_q <= res.next_pc;
            end
            assign pc_q_o = pc_q;
        end else begin : g_pc_pass
            assign pc_q_o = res.next_pc;
        end
    endgenerate
endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter bit REG_PC = 1'b1
)(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_val_o,
    input logic [XLEN-1:0] pc_q_o
);
    logic [XLEN-1:0] seq_w;
    op_t             op_w;
    assign seq_w = pc_i + 32'd4;
    assign op_w  = instr_i[XLEN-1 -: OPW];

    // R9
    link_only_jal_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> op_w == OP_JLINK);

    // R3
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> link_val_o == pc_i + 32'd8);

    // R2
    region_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (op_w == OP_JREGION) |->
            (next_pc_o[1:0] == 2'b00 && next_pc_o[XLEN-1 -: REGION] == seq_w[XLEN-1 -: REGION]));

    // R4
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (op_w == OP_SPECIAL && instr_i[FUNCW-1:0] == FN_JREG) |-> next_pc_o == rs_val_i);

    // R1
    unlisted_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_w > OP_BRGTZ) |-> (next_pc_o == seq_w && !link_we_o));

    generate
        if (REG_PC) begin : g_pc_chk
            // R10
            pc_reset_chk: assert property (@(posedge clk)
                rst |=> pc_q_o == '0);
            // R10
            pc_load_chk: assert property (@(posedge clk) disable iff (rst)
                !rst |=> pc_q_o == $past(next_pc_o));
        end
    endgenerate
endmodule

bind npc_unit npc_unit_chk #(.REG_PC(REG_PC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_i       (pc_i),
    .instr_i    (instr_i),
    .rs_val_i   (rs_val_i),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o),
    .pc_q_o     (pc_q_o)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rd_val_i = '0;
    logic [31:0] next_pc_o, link_val_o, pc_q_o;
    logic        link_we_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5ns clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rd_val_i(rd_val_i),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o),
        .link_val_o(link_val_o), .pc_q_o(pc_q_o)
    );

    function automatic string req_tag(input logic [31:0] ins);
        case (ins[31:26])
            6'h0: return "R4";
            6'h1: return "R7";
            6'h2: return "R2";
            6'h3: return "R3";
            6'h4: return "R5";
            6'h5: return "R6";
            6'h6, 6'h7: return "R8";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [31:0] ref_next(input logic [31:0] pc, ins, a, b);
        logic [31:0] seq, br, jt;
        logic signed [31:0] sa;
        logic tk;
        seq = pc + 32'd4;
        br  = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
        jt  = {seq[31:28], ins[25:0], 2'b00};
        sa  = a;
        tk  = 1'b0;
        case (ins[31:26])
            6'h0: return (ins[5:0] == 6'h08) ? a : seq;
            6'h2, 6'h3: return jt;
            6'h4: tk = (a == b);
            6'h5: tk = (a != b);
            6'h1: begin
                if (ins[20:16] == 5'd0)      tk = (sa < 0);
                else if (ins[20:16] == 5'd1) tk = (sa >= 0);
            end
            6'h6: tk = (ins[20:16] == 5'd0) && (sa <= 0);
            6'h7: tk = (ins[20:16] == 5'd0) && (sa > 0);
            default: tk = 1'b0;
        endcase
        return tk ? br : seq;
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    logic [31:0] pend_pc;

    // apply a vector after a falling edge, check outputs, then the register
    task automatic apply(input logic [31:0] pc, ins, a, b);
        logic [31:0] en;
        logic        ew;
        string       t;
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = a; rd_val_i = b;
        #1ns;
        en = ref_next(pc, ins, a, b);
        ew = (ins[31:26] == 6'h3);
        t  = req_tag(ins);
        check32(t, "next_pc", next_pc_o, en);
        check32(ew ? "R3" : "R9", "link_we", {31'd0, link_we_o}, {31'd0, ew});
        if (ew) check32("R3", "link_val", link_val_o, pc + 32'd8);
        pend_pc = en;
        @(posedge clk);
        #1ns;
        check32("R10", "pc_q load", pc_q_o, pend_pc);
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] sub,
                                       input logic [15:0] low);
        return {op, 5'd3, sub, low};
    endfunction

    initial begin
        #1ms;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        pc_i = 32'h0000_1000; instr_i = 32'h1000_0004;
        repeat (3) @(posedge clk);
        #1ns;
        check32("R10", "pc_q reset", pc_q_o, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // directed corner cases
        apply(32'hA000_0010, mk(6'h02, 5'd0, 16'h0000) | 32'h03FF_FFFF, 0, 0);   // R2
        apply(32'hFFFF_FFFC, mk(6'h03, 5'd0, 16'h1234), 0, 0);                  // R3 wrap
        apply(32'h0040_0000, {6'h0, 5'd1, 5'd2, 5'd0, 5'd0, 6'h08}, 32'hDECA_FE00, 0); // R4
        apply(32'h0040_0000, {6'h0, 5'd1, 5'd2, 5'd0, 5'd0, 6'h09}, 32'hDECA_FE00, 0); // R4 other funct
        apply(32'h0000_0100, mk(6'h04, 5'd0, 16'hFFF0), 32'd7, 32'd7);           // R5 backward
        apply(32'h0000_0100, mk(6'h04, 5'd0, 16'h0010), 32'd7, 32'd8);           // R5 not taken
        apply(32'h0000_0100, mk(6'h05, 5'd0, 16'h0010), 32'd7, 32'd8);           // R6
        apply(32'h0000_0100, mk(6'h05, 5'd0, 16'h0010), 32'd9, 32'd9);           // R6 not taken
        apply(32'h0000_0200, mk(6'h01, 5'd0, 16'h0004), 32'h8000_0000, 0);       // R7 BLTZ
        apply(32'h0000_0200, mk(6'h01, 5'd1, 16'h0004), 32'h0, 0);               // R7 BGEZ zero
        apply(32'h0000_0200, mk(6'h01, 5'd2, 16'h0004), 32'h8000_0000, 0);       // R7 bad sub
        apply(32'h0000_0300, mk(6'h06, 5'd0, 16'h0008), 32'h0, 0);               // R8 BLEZ zero
        apply(32'h0000_0300, mk(6'h07, 5'd0, 16'h0008), 32'h0, 0);               // R8 BGTZ zero
        apply(32'h0000_0300, mk(6'h07, 5'd0, 16'h0008), 32'h7FFF_FFFF, 0);       // R8 BGTZ max
        apply(32'h0000_0300, mk(6'h06, 5'd3, 16'h0008), 32'hFFFF_FFFF, 0);       // R8 bad sub
        apply(32'h0000_0400, mk(6'h3F, 5'd0, 16'h0008), 0, 0);                   // R1

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] pc, ins, a, b;
            logic [5:0]  op;
            logic [4:0]  sub;
            int          r;
            r   = $urandom % 10;
            op  = (r < 8) ? 6'(r) : 6'($urandom);
            sub = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 2);
            ins = $urandom;
            ins[31:26] = op;
            ins[20:16] = sub;
            if ($urandom % 2 == 0) ins[5:0] = 6'h08;
            pc = $urandom & 32'hFFFF_FFFC;
            case ($urandom % 4)
                0: a = 32'd0;
                1: a = $urandom | 32'h8000_0000;
                2: a = $urandom;
                default: a = $urandom % 16;
            endcase
            b = ($urandom % 2 == 0) ? a : $urandom;
            apply(pc, ins, a, b);
        end

        // reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1ns;
        check32("R10", "pc_q mid reset", pc_q_o, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule